// File: doc/BRIEF.md
# Pipelined Multiply-Accumulate Arithmetic Slice

This block is a hard-macro style arithmetic slice. A pre-adder forms a 25-bit operand from the D and A inputs, which helps when two filter taps share one coefficient. A signed 25x18 multiplier follows it. A 48-bit post-adder then adds or subtracts three operands. Each of the three operands is chosen every cycle by a 7-bit operand-select word. The sources are zero, the product, the concatenation A:B (the multiplier bypass), C, the registered result P, a cascade input from a neighbouring slice, and arithmetic right shifts by 17 of P or of the cascade input. The right shifts let several slices build a wider product.

Register stages sit at the input (operands and control), after the multiplier, and at the output. Each stage has its own clock enable and a synchronous active-low reset. The input and multiplier stages can be removed by parameter. The output register is always present, because it closes the accumulate loop.

The result drives the P output and the cascade output. It also feeds a pattern detector that flags a match of P, or of its complement, against a parameter pattern under a parameter mask. With Z selecting P and carry-in set, the slice works as a synchronous up or down counter.

Top module: `dsp_mac_slice`

## Requirements
- R1: A clock edge with rst_n low clears every pipeline register. After it, p and pcout are 0 and carry_out is 0. With the default pattern 0 and mask 0, pat_match is 1 and pat_match_inv is 0.
- R2: With all stages enabled and constant inputs, a product of A[24:0] and B (both two's complement) reaches p on the third rising edge after the operands are applied. After the second edge, p still shows the old value.
- R3: pre_mode chooses the multiplier's 25-bit operand. 0 gives A[24:0], 1 gives D+A[24:0], 2 gives D-A[24:0], 3 gives D. The result wraps to 25 bits.
- R4: opsel[1:0] picks X from {0, product, P, A:B}. opsel[3:2] picks Y from {0, product, all-ones, C}. opsel[6:4] picks Z: 0 is zero, 1 is pcin, 2 is P, 3 is C, 5 is pcin>>>17, 6 is P>>>17. A:B is A in the upper 30 bits and B in the lower 18 bits. When X and Y both select the product, the product is added once.
- R5: alu_op 3 computes Z-(X+Y+CIN). Every other alu_op value computes Z+X+Y+CIN.
- R6: When cin_sel is 0, CIN is the carry_in input. When cin_sel is 1, CIN is bit 47 of the current P.
- R7: The shifted Z sources are arithmetic right shifts by 17, with the sign bit copied into the vacated bits.
- R8: Some operand-select words are invalid: Z code 4 or 7, or exactly one of X and Y selecting the product. An invalid word leaves p and carry_out unchanged on an enabled edge.
- R9: carry_out is bit 48 of the 49-bit result. For add this is {0,Z}+{0,X}+{0,Y}+CIN. For subtract it is {0,Z}-({0,X}+{0,Y}+CIN). carry_out is registered with P.
- R10: pat_match is 1 when P equals PATTERN on every bit that MASK does not set. pat_match_inv is 1 when P equals the complement of PATTERN on those bits.
- R11: ce_in, ce_m and ce_p each freeze their own stage while low. Input changes made during that time do not reach p.
- R12: With X=0, Y=0, Z=P, CIN=1, p counts up by one each cycle. With alu_op 3, it counts down by one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_in | input | 1 | Clock enable, input stage (operands and controls) |
| ce_m | input | 1 | Clock enable, multiplier stage |
| ce_p | input | 1 | Clock enable, output stage |
| a | input | 30 | Operand A, low 25 bits to pre-adder, all bits to A:B |
| b | input | 18 | Operand B |
| c | input | 48 | Operand C |
| d | input | 25 | Pre-adder operand D |
| pre_mode | input | 2 | Pre-adder function |
| opsel | input | 7 | Operand-select word (Z, Y, X) |
| alu_op | input | 2 | Post-adder function |
| cin_sel | input | 1 | Carry-in source select |
| carry_in | input | 1 | External carry-in |
| pcin | input | 48 | Cascade input from a neighbour slice |
| p | output | 48 | Result |
| pcout | output | 48 | Cascade output |
| carry_out | output | 1 | Bit 48 of the post-adder result |
| pat_match | output | 1 | P matches pattern under mask |
| pat_match_inv | output | 1 | P matches inverted pattern under mask |

## Verification
The hardest cases to reach are those where the result depends on feedback from P. Examples are carry-in taken from the sign of P, the P>>>17 path, and a multi-cycle count. In these cases an error early in the sequence only shows up several cycles later. The stimulus first loads P with a known signed value through the C path. It then switches the controls and checks p after a counted number of edges. The count includes the one edge in which the new control word meets the old product. A table of mode words, run with changing operands and sign-extreme values, is compared every cycle with a bench model.

// File: rtl/dsp_mac_pkg.sv
// Shared encodings for the multiply-accumulate slice.
// Assumes the operand-select word is laid out as {Z[2:0], Y[1:0], X[1:0]}.
package dsp_mac_pkg;

    typedef enum logic [1:0] {
        XS_ZERO = 2'd0,
        XS_MUL  = 2'd1,
        XS_P    = 2'd2,
        XS_AB   = 2'd3
    } xsel_e;

    typedef enum logic [1:0] {
        YS_ZERO = 2'd0,
        YS_MUL  = 2'd1,
        YS_ONES = 2'd2,
        YS_C    = 2'd3
    } ysel_e;

    typedef enum logic [2:0] {
        ZS_ZERO    = 3'd0,
        ZS_CASC    = 3'd1,
        ZS_P       = 3'd2,
        ZS_C       = 3'd3,
        ZS_BAD4    = 3'd4,
        ZS_CASC_SH = 3'd5,
        ZS_P_SH    = 3'd6,
        ZS_BAD7    = 3'd7
    } zsel_e;

    typedef enum logic [1:0] {
        PRE_A     = 2'd0,
        PRE_D_ADD = 2'd1,
        PRE_D_SUB = 2'd2,
        PRE_D     = 2'd3
    } pre_e;

    localparam logic [1:0] ALU_SUB = 2'd3;

endpackage

// File: rtl/dsp_pipe_reg.sv
// Optional pipeline register with clock enable and synchronous active-low reset.
// With EN = 0 it becomes a plain wire, and clk, rst_n and ce are unused.
module dsp_pipe_reg #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ce,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (EN) begin : g_reg
            logic [W-1:0] q_r;
            // Capture d on an enabled edge, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n)  q_r <= '0;
                else if (ce) q_r <= d;
            end
            assign q = q_r;
        end else begin : g_wire
            logic unused_ok;
            assign unused_ok = clk ^ rst_n ^ ce;
            assign q = d;
        end
    endgenerate
endmodule

// File: rtl/dsp_mult_stage.sv
// Pre-adder followed by a signed multiplier.
// Assumes PW >= MAW + BW. The product is sign-extended to PW bits.
module dsp_mult_stage
    import dsp_mac_pkg::*;
#(
    parameter int MAW = 25,
    parameter int BW  = 18,
    parameter int PW  = 48
) (
    input  logic [MAW-1:0] a_lo,
    input  logic [MAW-1:0] d,
    input  logic [BW-1:0]  b,
    input  logic [1:0]     pre_mode,
    output logic [PW-1:0]  prod
);
    localparam int MW  = MAW + BW;
    localparam int EXT = PW - MW;

    logic [MAW-1:0]        pre_sum;
    logic signed [MW-1:0]  full;

    // Pre-adder: choose A, D+A, D-A or D, wrapped to MAW bits.
    always_comb begin
        unique case (pre_e'(pre_mode))
            PRE_A:     pre_sum = a_lo;
            PRE_D_ADD: pre_sum = d + a_lo;
            PRE_D_SUB: pre_sum = d - a_lo;
            default:   pre_sum = d;
        endcase
    end

    // Signed product, sign-extended to the post-adder width.
    always_comb begin
        full = MW'($signed(pre_sum) * $signed(b));
        prod = {{EXT{full[MW-1]}}, full};
    end
endmodule

// File: rtl/dsp_post_alu.sv
// Operand muxes and post-adder/subtracter, with carry-in select.
// Flags invalid select words so the output stage can hold its value.
// Assumes AW + BW <= PW and that p_cur is the registered result.
module dsp_post_alu
    import dsp_mac_pkg::*;
#(
    parameter int AW = 30,
    parameter int BW = 18,
    parameter int PW = 48,
    parameter int SH = 17
) (
    input  logic [PW-1:0] prod,
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic [PW-1:0] c,
    input  logic [PW-1:0] p_cur,
    input  logic          cout_cur,
    input  logic [PW-1:0] pcin,
    input  logic [6:0]    opsel,
    input  logic [1:0]    alu_op,
    input  logic          cin_sel,
    input  logic          carry_in,
    output logic [PW-1:0] p_nxt,
    output logic          cout_nxt,
    output logic          sel_ok
);
    xsel_e         xs;
    ysel_e         ys;
    zsel_e         zs;
    logic [PW-1:0] xv, yv, zv;
    logic          cin;
    logic [PW:0]   addend, res;

    assign xs = xsel_e'(opsel[1:0]);
    assign ys = ysel_e'(opsel[3:2]);
    assign zs = zsel_e'(opsel[6:4]);

    // Validity of the select word: the product goes through X and Y together, Z codes 4/7 are invalid.
    assign sel_ok = ((xs == XS_MUL) == (ys == YS_MUL)) && (zs != ZS_BAD4) && (zs != ZS_BAD7);

    // X source mux.
    always_comb begin
        unique case (xs)
            XS_ZERO: xv = '0;
            XS_MUL:  xv = prod;
            XS_P:    xv = p_cur;
            default: xv = PW'({a, b});
        endcase
    end

    // Y source mux. A product pair in X and Y counts once.
    always_comb begin
        unique case (ys)
            YS_ZERO: yv = '0;
            YS_MUL:  yv = '0;
            YS_ONES: yv = '1;
            default: yv = c;
        endcase
    end

    // Z source mux, including the arithmetic shifts.
    always_comb begin
        unique case (zs)
            ZS_CASC:    zv = pcin;
            ZS_P:       zv = p_cur;
            ZS_C:       zv = c;
            ZS_CASC_SH: zv = PW'($signed(pcin) >>> SH);
            ZS_P_SH:    zv = PW'($signed(p_cur) >>> SH);
            default:    zv = '0;
        endcase
    end

    // Carry-in source: external bit or the sign of the current result.
    assign cin = cin_sel ? p_cur[PW-1] : carry_in;

    // Add or subtract in PW+1 bits; the top bit is the carry-out.
    always_comb begin
        addend = {1'b0, xv} + {1'b0, yv} + {{PW{1'b0}}, cin};
        if (alu_op == ALU_SUB) res = {1'b0, zv} - addend;
        else                   res = {1'b0, zv} + addend;
        p_nxt    = sel_ok ? res[PW-1:0] : p_cur;
        cout_nxt = sel_ok ? res[PW]     : cout_cur;
    end
endmodule

// File: rtl/dsp_mac_slice.sv
// Top of the multiply-accumulate slice: input stage, multiplier stage and output stage.
// The output stage is always registered because P feeds back into the post-adder.
// Assumes A_W + B_W <= P_W and MUL_A_W + B_W <= P_W, and MUL_A_W <= A_W.
module dsp_mac_slice
    import dsp_mac_pkg::*;
#(
    parameter int           A_W        = 30,
    parameter int           B_W        = 18,
    parameter int           MUL_A_W    = 25,
    parameter int           P_W        = 48,
    parameter int           CASC_SHIFT = 17,
    parameter logic [47:0]  PATTERN    = 48'h0,
    parameter logic [47:0]  MASK       = 48'h0,
    parameter bit           A_REG      = 1'b1,
    parameter bit           B_REG      = 1'b1,
    parameter bit           C_REG      = 1'b1,
    parameter bit           D_REG      = 1'b1,
    parameter bit           CTL_REG    = 1'b1,
    parameter bit           M_REG      = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_in,
    input  logic               ce_m,
    input  logic               ce_p,
    input  logic [A_W-1:0]     a,
    input  logic [B_W-1:0]     b,
    input  logic [P_W-1:0]     c,
    input  logic [MUL_A_W-1:0] d,
    input  logic [1:0]         pre_mode,
    input  logic [6:0]         opsel,
    input  logic [1:0]         alu_op,
    input  logic               cin_sel,
    input  logic               carry_in,
    input  logic [P_W-1:0]     pcin,
    output logic [P_W-1:0]     p,
    output logic [P_W-1:0]     pcout,
    output logic               carry_out,
    output logic               pat_match,
    output logic               pat_match_inv
);
    localparam int CTL_W = 2 + 7 + 2 + 1 + 1;

    logic [A_W-1:0]     a_q;
    logic [B_W-1:0]     b_q;
    logic [P_W-1:0]     c_q;
    logic [MUL_A_W-1:0] d_q;
    logic [CTL_W-1:0]   ctl_q;
    logic [1:0]         pre_q, alu_q;
    logic [6:0]         opsel_q;
    logic               cin_sel_q, carry_in_q;
    logic [P_W-1:0]     prod, prod_q, p_nxt;
    logic               cout_nxt, sel_ok;
    logic [P_W-1:0]     p_q;
    logic               cout_q;
    logic [P_W-1:0]     pat_w, mask_w;

    dsp_pipe_reg #(.W(A_W),     .EN(A_REG))   u_a_reg (.clk(clk), .rst_n(rst_n), .ce(ce_in), .d(a), .q(a_q));
    dsp_pipe_reg #(.W(B_W),     .EN(B_REG))   u_b_reg (.clk(clk), .rst_n(rst_n), .ce(ce_in), .d(b), .q(b_q));
    dsp_pipe_reg #(.W(P_W),     .EN(C_REG))   u_c_reg (.clk(clk), .rst_n(rst_n), .ce(ce_in), .d(c), .q(c_q));
    dsp_pipe_reg #(.W(MUL_A_W), .EN(D_REG))   u_d_reg (.clk(clk), .rst_n(rst_n), .ce(ce_in), .d(d), .q(d_q));
    dsp_pipe_reg #(.W(CTL_W),   .EN(CTL_REG)) u_ctl_reg (
        .clk(clk), .rst_n(rst_n), .ce(ce_in),
        .d({pre_mode, opsel, alu_op, cin_sel, carry_in}), .q(ctl_q));

    assign {pre_q, opsel_q, alu_q, cin_sel_q, carry_in_q} = ctl_q;

    dsp_mult_stage #(.MAW(MUL_A_W), .BW(B_W), .PW(P_W)) u_mult (
        .a_lo(a_q[MUL_A_W-1:0]), .d(d_q), .b(b_q), .pre_mode(pre_q), .prod(prod));

    dsp_pipe_reg #(.W(P_W), .EN(M_REG)) u_m_reg (.clk(clk), .rst_n(rst_n), .ce(ce_m), .d(prod), .q(prod_q));

    dsp_post_alu #(.AW(A_W), .BW(B_W), .PW(P_W), .SH(CASC_SHIFT)) u_alu (
        .prod(prod_q), .a(a_q), .b(b_q), .c(c_q), .p_cur(p_q), .cout_cur(cout_q),
        .pcin(pcin), .opsel(opsel_q), .alu_op(alu_q), .cin_sel(cin_sel_q),
        .carry_in(carry_in_q), .p_nxt(p_nxt), .cout_nxt(cout_nxt), .sel_ok(sel_ok));

    // Output stage: result and carry-out, the feedback point of the accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q    <= '0;
            cout_q <= 1'b0;
        end else if (ce_p) begin
            p_q    <= p_nxt;
            cout_q <= cout_nxt;
        end
    end

    assign pat_w  = P_W'(PATTERN);
    assign mask_w = P_W'(MASK);

    // Pattern detector on the registered result, masked bits ignored.
    always_comb begin
        pat_match     = ((p_q ^  pat_w) & ~mask_w) == '0;
        pat_match_inv = ((p_q ^ ~pat_w) & ~mask_w) == '0;
    end

    assign p         = p_q;
    assign pcout     = p_q;
    assign carry_out = cout_q;

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (p == '0 && !carry_out));

    assert_invalid_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_p && !sel_ok) |=> ($stable(p) && $stable(carry_out)));

    assert_ce_p_freezes_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_p |=> ($stable(p) && $stable(carry_out)));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (~mask_w != '0) |-> !(pat_match && pat_match_inv));

    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_p && opsel_q == 7'b010_00_00 && alu_q != ALU_SUB && !cin_sel_q && carry_in_q)
        |=> (p == $past(p) + 1'b1));
endmodule

// File: tb/dsp_mac_slice_bench.sv
// Bench for the multiply-accumulate slice. A mode table is walked with changing
// operands and compared against a cycle model, then directed tests with hand values.
module dsp_mac_slice_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_in = 1'b1, ce_m = 1'b1, ce_p = 1'b1;
    logic [29:0] a = '0;
    logic [17:0] b = '0;
    logic [47:0] c = '0;
    logic [24:0] d = '0;
    logic [1:0]  pre_mode = '0, alu_op = '0;
    logic [6:0]  opsel = '0;
    logic        cin_sel = 1'b0, carry_in = 1'b0;
    logic [47:0] pcin = '0;
    logic [47:0] p, pcout;
    logic        carry_out, pat_match, pat_match_inv;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dsp_mac_slice u_dsp_mac_slice (
        .clk(clk), .rst_n(rst_n), .ce_in(ce_in), .ce_m(ce_m), .ce_p(ce_p),
        .a(a), .b(b), .c(c), .d(d), .pre_mode(pre_mode), .opsel(opsel),
        .alu_op(alu_op), .cin_sel(cin_sel), .carry_in(carry_in), .pcin(pcin),
        .p(p), .pcout(pcout), .carry_out(carry_out),
        .pat_match(pat_match), .pat_match_inv(pat_match_inv));

    // Reference model built from the requirements.
    function automatic logic [47:0] ref_prod(input logic [29:0] ai, input logic [24:0] di,
                                            input logic [17:0] bi, input logic [1:0] pm);
        logic signed [24:0] op;
        logic signed [42:0] pr;
        case (pm)
            2'd0: op = ai[24:0];
            2'd1: op = di + ai[24:0];
            2'd2: op = di - ai[24:0];
            default: op = di;
        endcase
        pr = 43'(op * $signed(bi));
        return 48'($signed(pr));
    endfunction

    function automatic logic [49:0] ref_alu(input logic [47:0] pr, ai_b, ci, pc, pci,
                                            input logic co, input logic [6:0] os,
                                            input logic [1:0] al, input logic cs, ci_in);
        logic [47:0] x, y, z;
        logic [48:0] t, r;
        logic ok, cy;
        ok = ((os[1:0] == 2'd1) == (os[3:2] == 2'd1)) && os[6:4] != 3'd4 && os[6:4] != 3'd7;
        x = (os[1:0] == 2'd1) ? pr : (os[1:0] == 2'd2) ? pc : (os[1:0] == 2'd3) ? ai_b : 48'd0;
        y = (os[3:2] == 2'd2) ? '1 : (os[3:2] == 2'd3) ? ci : 48'd0;
        case (os[6:4])
            3'd1: z = pci;
            3'd2: z = pc;
            3'd3: z = ci;
            3'd5: z = 48'($signed(pci) >>> 17);
            3'd6: z = 48'($signed(pc) >>> 17);
            default: z = '0;
        endcase
        cy = cs ? pc[47] : ci_in;
        t = {1'b0, x} + {1'b0, y} + 49'(cy);
        r = (al == 2'd3) ? ({1'b0, z} - t) : ({1'b0, z} + t);
        return ok ? {1'b1, r} : {1'b0, co, pc};
    endfunction

    logic [29:0] ma; logic [17:0] mb; logic [47:0] mc; logic [24:0] md;
    logic [1:0] mpre, malu; logic [6:0] mos; logic mcs, mci;
    logic [47:0] mm, mp; logic mco;
    logic [49:0] mres;

    assign mres = ref_alu(mm, {ma, mb}, mc, mp, pcin, mco, mos, malu, mcs, mci);

    // Model register update, mirroring the three stages.
    always @(posedge clk) begin
        if (!rst_n) begin
            ma <= '0; mb <= '0; mc <= '0; md <= '0; mpre <= '0; malu <= '0;
            mos <= '0; mcs <= 1'b0; mci <= 1'b0; mm <= '0; mp <= '0; mco <= 1'b0;
        end else begin
            if (ce_in) begin
                ma <= a; mb <= b; mc <= c; md <= d; mpre <= pre_mode;
                malu <= alu_op; mos <= opsel; mcs <= cin_sel; mci <= carry_in;
            end
            if (ce_m) mm <= ref_prod(ma, md, mb, mpre);
            if (ce_p) begin mp <= mres[47:0]; mco <= mres[48]; end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_p(input string tag, input logic [47:0] exp);
        chk(p === exp && pcout === exp, tag, p, exp);
    endtask

    task automatic drive(input logic [29:0] ai, input logic [17:0] bi, input logic [47:0] ci,
                         input logic [24:0] di, input logic [1:0] pm, input logic [6:0] os,
                         input logic [1:0] al, input logic cs, input logic cy);
        @(negedge clk);
        a = ai; b = bi; c = ci; d = di; pre_mode = pm; opsel = os;
        alu_op = al; cin_sel = cs; carry_in = cy;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Mode table: {pre_mode, opsel, alu_op, cin_sel}.
    localparam logic [11:0] MODES [8] = '{
        {2'd0, 7'b000_01_01, 2'd0, 1'b0},
        {2'd1, 7'b010_01_01, 2'd0, 1'b0},
        {2'd2, 7'b011_01_01, 2'd3, 1'b0},
        {2'd0, 7'b010_11_11, 2'd0, 1'b1},
        {2'd0, 7'b101_10_10, 2'd0, 1'b0},
        {2'd3, 7'b110_01_01, 2'd0, 1'b0},
        {2'd0, 7'b011_00_01, 2'd0, 1'b0},
        {2'd0, 7'b001_00_11, 2'd3, 1'b0}
    };

    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;
    function automatic logic [63:0] nxt(input logic [63:0] s);
        logic [63:0] v;
        v = s ^ (s << 13);
        v = v ^ (v >> 7);
        return v ^ (v << 17);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 48'd0, 48'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        edges(2);
        // R1: reset state
        chk_p("R1 p after reset", 48'd0);
        chk(!carry_out && pat_match && !pat_match_inv, "R1 flags after reset",
            {45'd0, carry_out, pat_match, pat_match_inv}, 48'd2);
        @(negedge clk); rst_n = 1'b1;

        // R2: latency, p unchanged after two edges, product after three
        drive(30'd3, -18'sd5, 48'd0, 25'd0, 2'd0, 7'b000_01_01, 2'd0, 1'b0, 1'b0);
        edges(2);
        chk_p("R2 p before latency", 48'd0);
        edges(1);
        chk_p("R2 product 3*-5", -48'sd15);

        // R3: pre-adder functions, d=10 a=4 b=2
        drive(30'd4, 18'd2, 48'd0, 25'd10, 2'd1, 7'b000_01_01, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R3 (D+A)*B", 48'd28);
        drive(30'd4, 18'd2, 48'd0, 25'd10, 2'd2, 7'b000_01_01, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R3 (D-A)*B", 48'd12);
        drive(30'd4, 18'd2, 48'd0, 25'd10, 2'd3, 7'b000_01_01, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R3 D*B", 48'd20);

        // R4: operand sources
        drive(30'd1, 18'd2, 48'd0, 25'd0, 2'd0, 7'b000_00_11, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R4 X=A:B", 48'h40002);
        drive(30'd0, 18'd0, 48'd100, 25'd0, 2'd0, 7'b000_11_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R4 Y=C", 48'd100);
        drive(30'd0, 18'd0, 48'd100, 25'd0, 2'd0, 7'b011_10_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R4 Z=C plus Y=ones", 48'd99);

        // R5: subtract and unsupported codes
        drive(30'd0, 18'd30, 48'd100, 25'd0, 2'd0, 7'b011_00_11, 2'd3, 1'b0, 1'b0);
        edges(4); chk_p("R5 C-A:B", 48'd70);
        drive(30'd0, 18'd30, 48'd100, 25'd0, 2'd0, 7'b011_00_11, 2'd1, 1'b0, 1'b0);
        edges(4); chk_p("R5 code 1 adds", 48'd130);
        drive(30'd0, 18'd30, 48'd100, 25'd0, 2'd0, 7'b011_00_11, 2'd2, 1'b0, 1'b0);
        edges(4); chk_p("R5 code 2 adds", 48'd130);

        // R6: carry-in sources
        drive(30'd0, 18'd0, 48'd100, 25'd0, 2'd0, 7'b011_00_00, 2'd0, 1'b0, 1'b1);
        edges(4); chk_p("R6 external carry-in", 48'd101);
        drive(30'd0, 18'd0, -48'sd4, 25'd0, 2'd0, 7'b011_00_00, 2'd0, 1'b1, 1'b0);
        edges(4); chk_p("R6 carry-in from sign of P", -48'sd3);

        // R7: arithmetic shift of cascade input and of P
        pcin = -48'sd1048576;
        drive(30'd0, 18'd0, 48'd0, 25'd0, 2'd0, 7'b101_00_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R7 pcin>>>17", -48'sd8);
        drive(30'd0, 18'd0, 48'd0, 25'd0, 2'd0, 7'b001_00_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R7 pcin unshifted", -48'sd1048576);
        drive(30'd0, 18'd0, 48'd0, 25'd0, 2'd0, 7'b110_00_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R7 P>>>17 keeps sign", -48'sd1);

        // R8: invalid words hold P
        drive(30'd0, 18'd0, 48'd77, 25'd0, 2'd0, 7'b011_00_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R8 preload", 48'd77);
        drive(30'd1, 18'd1, 48'd5, 25'd0, 2'd0, 7'b011_00_01, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R8 X=M alone holds", 48'd77);
        drive(30'd1, 18'd1, 48'd5, 25'd0, 2'd0, 7'b100_00_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R8 Z code 4 holds", 48'd77);
        drive(30'd1, 18'd1, 48'd5, 25'd0, 2'd0, 7'b111_00_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R8 Z code 7 holds", 48'd77);

        // R11: stage enables freeze
        ce_p = 1'b0;
        drive(30'd0, 18'd0, 48'd500, 25'd0, 2'd0, 7'b011_00_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R11 ce_p low holds", 48'd77);
        ce_p = 1'b1;
        edges(2); chk_p("R11 ce_p high loads", 48'd500);
        @(negedge clk); ce_in = 1'b0; c = 48'd9;
        edges(4); chk_p("R11 ce_in low blocks input", 48'd500);
        @(negedge clk); ce_in = 1'b1;

        // R9 and R10: carry-out and pattern flags
        drive(30'd0, 18'd1, 48'hFFFF_FFFF_FFFF, 25'd0, 2'd0, 7'b011_00_11, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R9 wrap to zero", 48'd0);
        chk(carry_out === 1'b1, "R9 carry out on add", {47'd0, carry_out}, 48'd1);
        chk(pat_match && !pat_match_inv, "R10 match on zero", {46'd0, pat_match, pat_match_inv}, 48'd2);
        drive(30'd0, 18'd1, 48'd0, 25'd0, 2'd0, 7'b011_00_11, 2'd3, 1'b0, 1'b0);
        edges(4); chk_p("R9 borrow to all ones", 48'hFFFF_FFFF_FFFF);
        chk(carry_out === 1'b1, "R9 carry out on subtract", {47'd0, carry_out}, 48'd1);
        chk(!pat_match && pat_match_inv, "R10 inverse match", {46'd0, pat_match, pat_match_inv}, 48'd1);

        // R12: up then down counting
        drive(30'd0, 18'd0, 48'd0, 25'd0, 2'd0, 7'b000_00_00, 2'd0, 1'b0, 1'b0);
        edges(4); chk_p("R12 clear", 48'd0);
        drive(30'd0, 18'd0, 48'd0, 25'd0, 2'd0, 7'b010_00_00, 2'd0, 1'b0, 1'b1);
        edges(10); chk_p("R12 count up", 48'd9);
        drive(30'd0, 18'd0, 48'd0, 25'd0, 2'd0, 7'b010_00_00, 2'd3, 1'b0, 1'b1);
        edges(5); chk_p("R12 count down", 48'd6);

        // Table walk against the cycle model: R2 R3 R4 R5 R6 R7 R8 R9 R10 R12
        for (int m = 0; m < 8; m++) begin
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                chk(p === mp && carry_out === mco, "R4 table result", p, mp);
                chk(pat_match === (mp == 48'd0) && pat_match_inv === (mp == '1),
                    "R10 table flags", {46'd0, pat_match, pat_match_inv},
                    {46'd0, mp == 48'd0, mp == '1});
                lfsr = nxt(lfsr);
                a = lfsr[29:0]; b = lfsr[47:30]; d = lfsr[63:39];
                lfsr = nxt(lfsr);
                c = lfsr[47:0]; pcin = {lfsr[15:0], lfsr[63:32]};
                carry_in = lfsr[60];
                if (k % 4 == 3) begin a = 30'h0100_0000; b = 18'h2_0000; d = 25'h100_0000; end
                {pre_mode, opsel, alu_op, cin_sel} = MODES[m];
            end
        end
        edges(3);
        chk(p === mp && carry_out === mco, "R4 table final", p, mp);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule